// File: doc/BRIEF.md
# UART Register Emulation Bridge

This block is a two-sided register bank. One side looks to a host like the register map of a common 16550-class UART. The other side belongs to an embedded local processor, whose firmware stands in for the serial hardware. The host programs the line control byte, the scratch byte and the two divisor bytes at their usual offsets. It reads the modem status byte at offset 6.

The modem line states do not come from pins. The local processor writes them, and the bank derives the change and edge flags that the host expects to see. When the host writes either divisor byte, the local processor receives an interrupt request. That request stays up until firmware reads back the byte that changed, so firmware can apply the new baud setting.

Both sides run on one clock. Every read and write is a single-cycle strobe. Read data on both sides is combinational from the current address. The local side decodes only the low byte of its address.

Top module: `uart_regmirror`

## Requirements
- R1: After reset, the line control, scratch, divisor low, divisor high and modem status bytes all read 00h, and `loc_irq` is 0.
- R2: Modem status bits 7..4 (carrier detect, ring, data-set-ready, clear-to-send) change only when the local side writes local offset F6h, which loads `loc_wdata[7:4]`. A host write to offset 6 has no effect.
- R3: On a local write to F6h, modem status bit 3, bit 1 and bit 0 set to 1 if carrier detect, data-set-ready or clear-to-send changes value, respectively. Rewriting an unchanged value sets nothing.
- R4: Modem status bit 2 sets to 1 only when the ring bit goes from 1 to 0. A rising ring bit leaves bit 2 unchanged.
- R5: A host read of offset 6 returns the current modem status and then clears bits 3..0. A flag that is set in the same cycle as that read survives the clear.
- R6: The scratch byte at host offset 7 is read/write for the host and readable by the local side at F7h. A host write to it never raises `loc_irq`.
- R7: With the divisor-latch access bit set (bit 7 of the line control byte), host offsets 0 and 1 read and write the divisor low and high bytes. The local side reads these bytes at F8h and F9h.
- R8: With the divisor-latch access bit clear, host writes to offsets 0 and 1 leave the divisor bytes unchanged, and host reads of offsets 0 and 1 return 00h.
- R9: A host write to a divisor byte raises `loc_irq`. The request for each byte stays pending until the local side reads that byte (F8h for low, F9h for high). A new write in the same cycle as that read keeps the request pending.
- R10: The line control byte at host offset 3 is read/write for the host. Its bit 7 is the divisor-latch access bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 3 | Host register offset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data |
| loc_addr | input | LOC_AW (16) | Local address; only the low byte is decoded |
| loc_wr | input | 1 | Local write strobe |
| loc_rd | input | 1 | Local read strobe |
| loc_wdata | input | 8 | Local write data |
| loc_rdata | output | 8 | Local read data |
| loc_irq | output | 1 | Interrupt request to the local processor |

## Verification
The bench builds the block with its default parameters: a 16-bit local address and the local register offsets F6h through F9h. These defaults reach every decoded local location and leave undecoded upper address bits to be tied off. The host-side 3-bit map is fixed, so all of its offsets are reachable under both settings of the access bit. The interesting cases are the same-cycle collisions between the two sides: a status read racing a line-state write, and a divisor write racing the firmware read that would clear its request.

// File: rtl/uart_regmirror.sv
module uart_regmirror #(
  parameter int LOC_AW = 16,
  parameter logic [7:0] LOC_MSR_OFF = 8'hF6,
  parameter logic [7:0] LOC_SCR_OFF = 8'hF7,
  parameter logic [7:0] LOC_DLL_OFF = 8'hF8,
  parameter logic [7:0] LOC_DLM_OFF = 8'hF9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  input  logic [LOC_AW-1:0] loc_addr,
  input  logic              loc_wr,
  input  logic              loc_rd,
  input  logic [7:0]        loc_wdata,
  output logic [7:0]        loc_rdata,
  output logic              loc_irq
);
  localparam logic [2:0] H_DLL = 3'd0;
  localparam logic [2:0] H_DLM = 3'd1;
  localparam logic [2:0] H_LCR = 3'd3;
  localparam logic [2:0] H_MSR = 3'd6;
  localparam logic [2:0] H_SCR = 3'd7;

  logic [7:0] lcr_q, scr_q, div_lo, div_hi, msr_q;
  logic       pend_lo, pend_hi;

  wire [7:0] loc_off = loc_addr[7:0];
  wire       dlab    = lcr_q[7];

  wire hw_lo  = host_wr && dlab && host_addr == H_DLL;
  wire hw_hi  = host_wr && dlab && host_addr == H_DLM;
  wire hw_lcr = host_wr && host_addr == H_LCR;
  wire hw_scr = host_wr && host_addr == H_SCR;
  wire hr_msr = host_rd && host_addr == H_MSR;
  wire lw_msr = loc_wr && loc_off == LOC_MSR_OFF;
  wire lr_lo  = loc_rd && loc_off == LOC_DLL_OFF;
  wire lr_hi  = loc_rd && loc_off == LOC_DLM_OFF;

  wire unused_bits = &{1'b0, loc_wdata[3:0], loc_addr[LOC_AW-1:8]};

  // line bits: 7 carrier, 6 ring, 5 data-set-ready, 4 clear-to-send
  wire [3:0] old_lines = msr_q[7:4];
  wire [3:0] new_lines = loc_wdata[7:4];
  wire [3:0] flag_set  = lw_msr ? {old_lines[3] ^ new_lines[3],
                                   old_lines[2] & ~new_lines[2],
                                   old_lines[1] ^ new_lines[1],
                                   old_lines[0] ^ new_lines[0]} : 4'b0;
  wire [3:0] flag_kept = hr_msr ? 4'b0 : msr_q[3:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lcr_q   <= '0;
      scr_q   <= '0;
      div_lo  <= '0;
      div_hi  <= '0;
      msr_q   <= '0;
      pend_lo <= 1'b0;
      pend_hi <= 1'b0;
    end else begin
      if (hw_lcr) lcr_q  <= host_wdata;
      if (hw_scr) scr_q  <= host_wdata;
      if (hw_lo)  div_lo <= host_wdata;
      if (hw_hi)  div_hi <= host_wdata;
      msr_q[7:4] <= lw_msr ? new_lines : old_lines;
      msr_q[3:0] <= flag_kept | flag_set;
      pend_lo <= hw_lo | (pend_lo & ~lr_lo);
      pend_hi <= hw_hi | (pend_hi & ~lr_hi);
    end
  end

  assign loc_irq = pend_lo | pend_hi;

  always_comb begin
    case (host_addr)
      H_DLL:   host_rdata = dlab ? div_lo : 8'h00;
      H_DLM:   host_rdata = dlab ? div_hi : 8'h00;
      H_LCR:   host_rdata = lcr_q;
      H_MSR:   host_rdata = msr_q;
      H_SCR:   host_rdata = scr_q;
      default: host_rdata = 8'h00;
    endcase
  end

  always_comb begin
    case (loc_off)
      LOC_MSR_OFF: loc_rdata = msr_q;
      LOC_SCR_OFF: loc_rdata = scr_q;
      LOC_DLL_OFF: loc_rdata = div_lo;
      LOC_DLM_OFF: loc_rdata = div_hi;
      default:     loc_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/uart_regmirror_chk.sv
module uart_regmirror_chk #(
  parameter logic [7:0] MSR_OFF = 8'hF6
) (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] host_addr,
  input logic       host_wr,
  input logic       host_rd,
  input logic [7:0] loc_off,
  input logic       loc_wr,
  input logic [7:0] loc_wdata,
  input logic       loc_irq,
  input logic [7:0] lcr_q,
  input logic [7:0] msr_q,
  input logic [7:0] div_lo,
  input logic [7:0] div_hi
);
  wire line_wr = loc_wr && loc_off == MSR_OFF;

  AST_LINES_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
    line_wr |=> msr_q[7:4] == $past(loc_wdata[7:4])); // R2
  AST_LINES_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !line_wr |=> $stable(msr_q[7:4])); // R2
  AST_RING_RISE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    line_wr && !msr_q[6] && loc_wdata[6] && !msr_q[2] && !(host_rd && host_addr == 3'd6) |=> !msr_q[2]); // R4
  AST_FLAGS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && host_addr == 3'd6 && !line_wr |=> msr_q[3:0] == 4'h0); // R5
  AST_SCRATCH_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && host_addr == 3'd7 && !loc_irq |=> !loc_irq); // R6
  AST_LATCH_GUARDED: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && !lcr_q[7] && host_addr <= 3'd1 |=> $stable(div_lo) && $stable(div_hi)); // R8
  AST_DIV_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && lcr_q[7] && host_addr <= 3'd1 |=> loc_irq); // R9
endmodule

bind uart_regmirror uart_regmirror_chk #(.MSR_OFF(LOC_MSR_OFF)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
  .host_rd(host_rd), .loc_off(loc_addr[7:0]), .loc_wr(loc_wr),
  .loc_wdata(loc_wdata), .loc_irq(loc_irq), .lcr_q(lcr_q), .msr_q(msr_q),
  .div_lo(div_lo), .div_hi(div_hi)
);

// File: tb/uart_regmirror_tb.sv
module uart_regmirror_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  host_addr = '0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic [15:0] loc_addr = '0;
  logic        loc_wr = 1'b0, loc_rd = 1'b0;
  logic [7:0]  loc_wdata = '0;
  logic [7:0]  loc_rdata;
  logic        loc_irq;
  logic        irq_probe = 1'b0;

  typedef struct { logic [7:0] exp; string req; } item_t;
  item_t sb[$];
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  uart_regmirror u_dut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .loc_addr(loc_addr), .loc_wr(loc_wr), .loc_rd(loc_rd),
    .loc_wdata(loc_wdata), .loc_rdata(loc_rdata), .loc_irq(loc_irq)
  );

  task automatic compare(input logic [7:0] act);
    item_t it;
    if (sb.size() == 0) begin
      n_chk++; n_bad++;
      $display("FAIL scoreboard empty: actual %02h expected none", act);
    end else begin
      it = sb.pop_front();
      n_chk++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual %02h expected %02h", it.req, act, it.exp);
      end
    end
  endtask

  always @(negedge clk) begin
    if (host_rd)   compare(host_rdata);
    if (loc_rd)    compare(loc_rdata);
    if (irq_probe) compare({7'b0, loc_irq});
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic hw(input logic [2:0] a, input logic [7:0] d);
    step(); host_addr = a; host_wdata = d; host_wr = 1'b1;
    step(); host_wr = 1'b0;
  endtask

  task automatic hr(input logic [2:0] a, input logic [7:0] e, input string r);
    step(); sb.push_back('{e, r}); host_addr = a; host_rd = 1'b1;
    step(); host_rd = 1'b0;
  endtask

  task automatic lw(input logic [7:0] a, input logic [7:0] d);
    step(); loc_addr = {8'h00, a}; loc_wdata = d; loc_wr = 1'b1;
    step(); loc_wr = 1'b0;
  endtask

  task automatic lr(input logic [7:0] a, input logic [7:0] e, input string r);
    step(); sb.push_back('{e, r}); loc_addr = {8'h00, a}; loc_rd = 1'b1;
    step(); loc_rd = 1'b0;
  endtask

  task automatic irq(input logic e, input string r);
    step(); sb.push_back('{{7'b0, e}, r}); irq_probe = 1'b1;
    step(); irq_probe = 1'b0;
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    // R1 reset values
    hr(3'd3, 8'h00, "R1 lcr"); hr(3'd6, 8'h00, "R1 msr"); hr(3'd7, 8'h00, "R1 scr");
    lr(8'hF8, 8'h00, "R1 dll"); lr(8'hF9, 8'h00, "R1 dlm"); irq(1'b0, "R1 irq");
    // R10 line control
    hw(3'd3, 8'h83); hr(3'd3, 8'h83, "R10 lcr readback");
    // R7 R9 divisor low
    hw(3'd0, 8'h34); irq(1'b1, "R9 irq after dll write");
    lr(8'hF9, 8'h00, "R7 dlm untouched"); irq(1'b1, "R9 irq held past other byte");
    lr(8'hF8, 8'h34, "R7 dll local"); irq(1'b0, "R9 irq cleared by read");
    hw(3'd1, 8'h12); lr(8'hF9, 8'h12, "R7 dlm local");
    hr(3'd0, 8'h34, "R7 dll host"); irq(1'b0, "R9 irq cleared dlm");
    // R8 access bit clear
    hw(3'd3, 8'h03); hw(3'd0, 8'hAA); hw(3'd1, 8'hBB);
    irq(1'b0, "R8 no irq"); hr(3'd0, 8'h00, "R8 off0 reads zero");
    hw(3'd3, 8'h80); hr(3'd0, 8'h34, "R8 dll kept"); hr(3'd1, 8'h12, "R8 dlm kept");
    hw(3'd3, 8'h03);
    // R6 scratch
    hw(3'd7, 8'h5A); irq(1'b0, "R6 no irq");
    hr(3'd7, 8'h5A, "R6 host scr"); lr(8'hF7, 8'h5A, "R6 local scr");
    // R2 R3 R4 R5 modem status
    lw(8'hF6, 8'hF0); hr(3'd6, 8'hFB, "R3 deltas, R4 rise quiet");
    hr(3'd6, 8'hF0, "R5 cleared");
    lw(8'hF6, 8'hF0); hr(3'd6, 8'hF0, "R3 no change no flag");
    lw(8'hF6, 8'hB0); hr(3'd6, 8'hB4, "R4 ring fall");
    hr(3'd6, 8'hB0, "R5 cleared again");
    hw(3'd6, 8'h00); hr(3'd6, 8'hB0, "R2 host write ignored");
    lr(8'hF6, 8'hB0, "R2 local view");
    // R5 same-cycle set wins
    step(); sb.push_back('{8'hB0, "R5 read during set"});
    host_addr = 3'd6; host_rd = 1'b1; loc_addr = 16'h00F6; loc_wdata = 8'h30; loc_wr = 1'b1;
    step(); host_rd = 1'b0; loc_wr = 1'b0;
    hr(3'd6, 8'h38, "R5 set survives clear"); hr(3'd6, 8'h30, "R5 then cleared");
    // R9 same-cycle write wins over read
    hw(3'd3, 8'h80);
    step(); sb.push_back('{8'h12, "R9 old dlm during write"});
    host_addr = 3'd1; host_wdata = 8'h77; host_wr = 1'b1; loc_addr = 16'h00F9; loc_rd = 1'b1;
    step(); host_wr = 1'b0; loc_rd = 1'b0;
    irq(1'b1, "R9 write wins"); lr(8'hF9, 8'h77, "R9 new dlm"); irq(1'b0, "R9 cleared");
    step(); step();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule